// File: doc/BRIEF.md
# Wave Execute Mask Controller

This block holds the execute mask of one wave. Each bit of the mask belongs to one lane: a 1 lets that lane take part in a vector operation and a 0 keeps it idle. Scalar instructions can replace the whole mask or either 32-bit half of it. A vector compare can also load its per-lane result into the mask.

Each cycle the block receives the class of the current operation and the wave-size mode, which selects 32 or 64 lanes. From the updated mask it produces registered per-lane enables. Vector ALU, vector memory, local shared memory, global shared memory and export operations are gated by the mask. Scalar ALU and branch operations get no lane enables. The block also reports the full mask value and a flag that is set when every active bit of the mask is zero.

All outputs are registered. After a clock edge they show the mask as updated at that edge, combined with the mode and operation class sampled at the same edge.

Top module: `exec_mask_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, mask_o is all ones, zero_o is 0 and lane_en_o is all zeros.
- R2: A scalar write with swr_sel_i = 0 loads all 64 bits of swr_data_i into the mask, and mask_o shows the new value after that edge.
- R3: A scalar write with swr_sel_i = 1 loads swr_data_i[31:0] into mask bits 31:0, and one with swr_sel_i = 2 loads swr_data_i[31:0] into mask bits 63:32. In both cases the other half keeps its value. A write with swr_sel_i = 3 leaves the mask unchanged.
- R4: A compare write loads all 64 bits of cmp_data_i when wide_mode_i = 1. When wide_mode_i = 0 it loads only bits 31:0, and bits 63:32 keep their value.
- R5: When a scalar write and a compare write occur in the same cycle, the scalar write decides every bit it covers.
- R6: For operation classes 2 to 6 (vector ALU, vector memory, local shared, global shared, export), lane_en_o after the edge equals the updated mask ANDed with the active lanes.
- R7: For operation classes 0 (scalar ALU), 1 (branch) and 7 (reserved), lane_en_o after the edge is all zeros, whatever the mask holds.
- R8: When wide_mode_i = 0, lane_en_o bits 63:32 are low.
- R9: zero_o is 1 when the updated mask is zero over the active width: all 64 bits when wide_mode_i = 1, and bits 31:0 only when wide_mode_i = 0.
- R10: mask_o always shows all 64 stored bits, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode_i | input | 1 | 1 = 64 lanes, 0 = 32 lanes |
| swr_en_i | input | 1 | Scalar write strobe |
| swr_sel_i | input | 2 | 0 full, 1 low half, 2 high half, 3 none |
| swr_data_i | input | 64 | Scalar write data (a half write uses bits 31:0) |
| cmp_en_i | input | 1 | Compare-result write strobe |
| cmp_data_i | input | 64 | Per-lane compare result |
| op_class_i | input | 3 | Operation class of the current instruction |
| lane_en_o | output | 64 | Registered per-lane enables |
| mask_o | output | 64 | Stored execute mask |
| zero_o | output | 1 | Active mask bits are all zero |

## Verification
A corrupted mask bit appears on mask_o on the edge after the faulty update. It also appears on lane_en_o for any vector class issued in that cycle, because both outputs are loaded from the same next-state value. A wrong width decision shows in two places: lanes 32 to 63 enabled during 32-lane operation, and a zero flag that disagrees with the low half. Both are visible one cycle after the mode is sampled. Merge errors in half writes and compare writes show up as changed bits in the half that should have kept its value, which the stimulus seeds with distinct patterns.

// File: rtl/exec_mask_pkg.sv
package exec_mask_pkg;
  typedef enum logic [2:0] {
    OP_SALU   = 3'd0,
    OP_BRANCH = 3'd1,
    OP_VALU   = 3'd2,
    OP_VMEM   = 3'd3,
    OP_LDS    = 3'd4,
    OP_GDS    = 3'd5,
    OP_EXPORT = 3'd6,
    OP_RSVD   = 3'd7
  } op_class_e;

  typedef enum logic [1:0] {
    WR_FULL = 2'd0,
    WR_LO   = 2'd1,
    WR_HI   = 2'd2,
    WR_NONE = 2'd3
  } wr_sel_e;

  // classes whose work is split over lanes
  function automatic logic uses_lanes(input logic [2:0] cls);
    return (cls >= OP_VALU) && (cls <= OP_EXPORT);
  endfunction
endpackage

// File: rtl/exec_mask_store.sv
module exec_mask_store
  import exec_mask_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide_mode,
  input  logic             swr_en,
  input  logic [1:0]       swr_sel,
  input  logic [LANES-1:0] swr_data,
  input  logic             cmp_en,
  input  logic [LANES-1:0] cmp_data,
  output logic [LANES-1:0] mask_q,
  output logic [LANES-1:0] mask_next
);
  localparam int HALF = LANES / 2;

  always_comb begin
    mask_next = mask_q;
    // compare result first, so a scalar write below overrides it
    if (cmp_en) begin
      if (wide_mode) mask_next = cmp_data;
      else           mask_next[HALF-1:0] = cmp_data[HALF-1:0];
    end
    if (swr_en) begin
      case (wr_sel_e'(swr_sel))
        WR_FULL: mask_next = swr_data;
        WR_LO:   mask_next[HALF-1:0] = swr_data[HALF-1:0];
        WR_HI:   mask_next[LANES-1:HALF] = swr_data[HALF-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= mask_next;
  end
endmodule

// File: rtl/exec_lane_gate.sv
module exec_lane_gate
  import exec_mask_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic             wide_mode,
  input  logic [2:0]       op_class,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] active,
  output logic [LANES-1:0] lane_en
);
  localparam int HALF = LANES / 2;

  logic vec_op;
  assign vec_op = uses_lanes(op_class);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i < HALF) begin : g_lo
      assign active[i] = 1'b1;
    end else begin : g_hi
      assign active[i] = wide_mode;
    end
    assign lane_en[i] = vec_op & active[i] & mask[i];
  end
endmodule

// File: rtl/exec_zero_detect.sv
module exec_zero_detect #(
  parameter int LANES = 64,
  parameter int CHUNK = 8
) (
  input  logic [LANES-1:0] mask,
  input  logic [LANES-1:0] active,
  output logic             all_zero
);
  localparam int NCHUNK = LANES / CHUNK;

  logic [LANES-1:0]  live;
  logic [NCHUNK-1:0] any_set;

  assign live = mask & active;

  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    assign any_set[c] = |live[c*CHUNK +: CHUNK];
  end

  assign all_zero = ~|any_set;
endmodule

// File: rtl/exec_mask_ctrl.sv
module exec_mask_ctrl #(
  parameter int LANES = 64,
  parameter int CHUNK = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide_mode_i,
  input  logic             swr_en_i,
  input  logic [1:0]       swr_sel_i,
  input  logic [LANES-1:0] swr_data_i,
  input  logic             cmp_en_i,
  input  logic [LANES-1:0] cmp_data_i,
  input  logic [2:0]       op_class_i,
  output logic [LANES-1:0] lane_en_o,
  output logic [LANES-1:0] mask_o,
  output logic             zero_o
);
  logic [LANES-1:0] mask_q, mask_next, active, lane_en_d;
  logic             zero_d;

  exec_mask_store #(.LANES(LANES)) u_store (
    .clk(clk), .rst(rst), .wide_mode(wide_mode_i),
    .swr_en(swr_en_i), .swr_sel(swr_sel_i), .swr_data(swr_data_i),
    .cmp_en(cmp_en_i), .cmp_data(cmp_data_i),
    .mask_q(mask_q), .mask_next(mask_next)
  );

  exec_lane_gate #(.LANES(LANES)) u_gate (
    .wide_mode(wide_mode_i), .op_class(op_class_i), .mask(mask_next),
    .active(active), .lane_en(lane_en_d)
  );

  exec_zero_detect #(.LANES(LANES), .CHUNK(CHUNK)) u_zero (
    .mask(mask_next), .active(active), .all_zero(zero_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_en_o <= '0;
      zero_o    <= 1'b0;
    end else begin
      lane_en_o <= lane_en_d;
      zero_o    <= zero_d;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/exec_mask_ctrl_chk.sv
module exec_mask_ctrl_chk #(
  parameter int LANES = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             wide_mode_i,
  input logic             swr_en_i,
  input logic [1:0]       swr_sel_i,
  input logic [LANES-1:0] swr_data_i,
  input logic             cmp_en_i,
  input logic [2:0]       op_class_i,
  input logic [LANES-1:0] lane_en_o,
  input logic [LANES-1:0] mask_o,
  input logic             zero_o
);
  localparam int HALF = LANES / 2;

  // R7
  scalar_no_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (op_class_i < 3'd2 || op_class_i == 3'd7) |=> (lane_en_o == '0));

  // R8
  narrow_upper_off_chk: assert property (@(posedge clk) disable iff (rst)
    !wide_mode_i |=> (lane_en_o[LANES-1:HALF] == '0));

  // R6
  lane_within_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ((lane_en_o & ~mask_o) == '0));

  // R5
  scalar_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (swr_en_i && swr_sel_i == 2'd0 && cmp_en_i) |=> (mask_o == $past(swr_data_i)));

  // R3
  none_sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (swr_en_i && swr_sel_i == 2'd3 && !cmp_en_i) |=> $stable(mask_o));

  // R9
  wide_zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wide_mode_i |=> (zero_o == (mask_o == '0)));
endmodule

bind exec_mask_ctrl exec_mask_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .wide_mode_i(wide_mode_i), .swr_en_i(swr_en_i),
  .swr_sel_i(swr_sel_i), .swr_data_i(swr_data_i), .cmp_en_i(cmp_en_i),
  .op_class_i(op_class_i), .lane_en_o(lane_en_o), .mask_o(mask_o),
  .zero_o(zero_o)
);

// File: tb/test_exec_mask_ctrl.sv
`timescale 1ns/1ps
module test_exec_mask_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode_i = 1'b1;
  logic        swr_en_i = 1'b0;
  logic [1:0]  swr_sel_i = 2'd3;
  logic [63:0] swr_data_i = '0;
  logic        cmp_en_i = 1'b0;
  logic [63:0] cmp_data_i = '0;
  logic [2:0]  op_class_i = 3'd0;
  logic [63:0] lane_en_o, mask_o;
  logic        zero_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  exec_mask_ctrl i_exec_mask_ctrl (
    .clk(clk), .rst(rst), .wide_mode_i(wide_mode_i), .swr_en_i(swr_en_i),
    .swr_sel_i(swr_sel_i), .swr_data_i(swr_data_i), .cmp_en_i(cmp_en_i),
    .cmp_data_i(cmp_data_i), .op_class_i(op_class_i),
    .lane_en_o(lane_en_o), .mask_o(mask_o), .zero_o(zero_o)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        md;
    logic        we;
    logic [1:0]  sel;
    logic [63:0] sd;
    logic        ce;
    logic [63:0] cd;
    logic [2:0]  cls;
    logic [63:0] em;
    logic [63:0] el;
    logic        ez;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    // R2 full write, vector ALU
    '{8'd2,  1'b1, 1'b1, 2'd0, 64'h0123_4567_89AB_CDEF, 1'b0, 64'h0, 3'd2,
      64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1'b0},
    // R7 scalar ALU gets no lanes
    '{8'd7,  1'b1, 1'b0, 2'd3, 64'h0, 1'b0, 64'h0, 3'd0,
      64'h0123_4567_89AB_CDEF, 64'h0, 1'b0},
    // R3 low-half write, vector memory
    '{8'd3,  1'b1, 1'b1, 2'd1, 64'h0, 1'b0, 64'h0, 3'd3,
      64'h0123_4567_0000_0000, 64'h0123_4567_0000_0000, 1'b0},
    // R9 narrow mode sees only the zero low half
    '{8'd9,  1'b0, 1'b0, 2'd3, 64'h0, 1'b0, 64'h0, 3'd4,
      64'h0123_4567_0000_0000, 64'h0, 1'b1},
    // R3 high-half write from data bits 31:0
    '{8'd3,  1'b0, 1'b1, 2'd2, 64'h0000_0000_FFFF_0000, 1'b0, 64'h0, 3'd5,
      64'hFFFF_0000_0000_0000, 64'h0, 1'b1},
    // R4 narrow compare loads low half only; R8 upper lanes off
    '{8'd4,  1'b0, 1'b0, 2'd3, 64'h0, 1'b1, 64'hAAAA_AAAA_5555_5555, 3'd6,
      64'hFFFF_0000_5555_5555, 64'h0000_0000_5555_5555, 1'b0},
    // R4 wide compare loads all bits
    '{8'd4,  1'b1, 1'b0, 2'd3, 64'h0, 1'b1, 64'h8000_0000_0000_0000, 3'd2,
      64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0},
    // R10 full mask still reported in narrow mode; R8 lane 63 off
    '{8'd10, 1'b0, 1'b0, 2'd3, 64'h0, 1'b0, 64'h0, 3'd2,
      64'h8000_0000_0000_0000, 64'h0, 1'b1},
    // R5 scalar beats compare; branch class has no lanes
    '{8'd5,  1'b1, 1'b1, 2'd0, 64'h0000_0000_0000_00F0, 1'b1, 64'h1111_1111_1111_1111, 3'd1,
      64'h0000_0000_0000_00F0, 64'h0, 1'b0},
    // R3 select 3 changes nothing; R6 lanes follow mask
    '{8'd3,  1'b1, 1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'h0, 3'd2,
      64'h0000_0000_0000_00F0, 64'h0000_0000_0000_00F0, 1'b0},
    // R9 wide all-zero mask
    '{8'd9,  1'b1, 1'b1, 2'd0, 64'h0, 1'b0, 64'h0, 3'd3,
      64'h0, 64'h0, 1'b1},
    // R7 reserved class has no lanes
    '{8'd7,  1'b1, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'h0, 3'd7,
      64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0},
    // R5 low-half scalar write beats narrow compare
    '{8'd5,  1'b0, 1'b1, 2'd1, 64'h0000_0000_0000_0001, 1'b1, 64'h0, 3'd2,
      64'hFFFF_FFFF_0000_0001, 64'h0000_0000_0000_0001, 1'b0}
  };

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag, input logic [63:0] em,
                               input logic [63:0] el, input logic ez);
    check64({tag, " mask"}, mask_o, em);
    check64({tag, " lanes"}, lane_en_o, el);
    check64({tag, " zero"}, {63'd0, zero_o}, {63'd0, ez});
  endtask

  task automatic idle_inputs();
    swr_en_i = 1'b0; cmp_en_i = 1'b0; swr_sel_i = 2'd3; op_class_i = 3'd0;
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 state while reset is held
    check_outputs("R1 in reset", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    // R1 first cycle after reset, idle scalar class
    check_outputs("R1 after reset", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      wide_mode_i = TBL[k].md;
      swr_en_i    = TBL[k].we;
      swr_sel_i   = TBL[k].sel;
      swr_data_i  = TBL[k].sd;
      cmp_en_i    = TBL[k].ce;
      cmp_data_i  = TBL[k].cd;
      op_class_i  = TBL[k].cls;
      @(negedge clk);
      check_outputs($sformatf("R%0d vector %0d", TBL[k].req, k),
                    TBL[k].em, TBL[k].el, TBL[k].ez);
    end
    idle_inputs();

    // R6 every vector class enables the full mask in wide mode
    wide_mode_i = 1'b1;
    swr_en_i = 1'b1; swr_sel_i = 2'd0; swr_data_i = 64'hC3C3_0F0F_F0F0_3C3C;
    op_class_i = 3'd2;
    @(negedge clk);
    swr_en_i = 1'b0;
    for (int c = 2; c <= 6; c++) begin
      op_class_i = 3'(c);
      @(negedge clk);
      check64($sformatf("R6 class %0d lanes", c), lane_en_o, 64'hC3C3_0F0F_F0F0_3C3C);
    end

    // R8 narrow mode keeps upper lanes low with an all-ones mask
    wide_mode_i = 1'b0;
    swr_en_i = 1'b1; swr_sel_i = 2'd0; swr_data_i = 64'hFFFF_FFFF_FFFF_FFFF;
    op_class_i = 3'd3;
    @(negedge clk);
    check64("R8 narrow lanes", lane_en_o, 64'h0000_0000_FFFF_FFFF);
    idle_inputs();

    // R1 mid-run reset restores the mask
    swr_en_i = 1'b1; swr_sel_i = 2'd0; swr_data_i = 64'h0; op_class_i = 3'd2;
    @(negedge clk);
    rst = 1'b1;
    idle_inputs();
    @(negedge clk);
    check_outputs("R1 mid-run reset", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule